// File: doc/BRIEF.md
# Majority-Gate Binary Adder with Two-Bit Carry Slices

This block adds two unsigned operands of a configurable even width, plus a single incoming carry. It returns the sum and the outgoing carry. It is purely combinational, and it is described only with a three-input vote (majority) function and inversion. No other logic operator appears in the datapath. AND and OR are obtained by pinning one vote input to a constant 0 or 1.

Bit positions are paired into two-bit slices. Each slice first forms the OR/AND pair of its lower bit, then computes two inner votes from its upper bit. The carry entering the slice reaches the slice's carry-out through one more vote only. The long carry chain therefore crosses one gate per two bits instead of one per bit. Sum bits are formed by a one-bit cell built from three votes and an inverter on its local carry.

The block is used wherever a shallow, regular ripple adder of 16, 32 or 64 bits is wanted.

Top module: `mjadd_top`

## Requirements
- R1: For every input, `{co_out, sum_out}` equals the WIDTH+1-bit value `op_a + op_b + ci_in`. The default WIDTH is 32.
- R2: `ci_in` is the carry into bit 0. All-ones plus zero with `ci_in`=1 gives sum 0 and `co_out`=1.
- R3: A carry born at bit 0 travels through every slice when all positions propagate. `55..55 + AA..AA` with `ci_in`=1 gives sum 0 and carry-out 1; with `ci_in`=0 it gives all ones and carry-out 0.
- R4: The carry leaving each two-bit slice equals `G1 | P1&(G0 | P0&cin)`, where `Gk = ak&bk` and `Pk = ak|bk`. The incoming carry enters only the outer vote. This carry agrees with the carry rippled bit by bit through the slice.
- R5: Each lower-bit OR term is formed by a vote with one input tied to 1, and each AND term by a vote with one input tied to 0. A generate with no carry in (`1+1`) and a propagate of a carry in (`1+0` with `ci_in`=1) both yield sum 2.
- R6: Each sum bit equals `a ^ b ^ c` of its own bit. It is computed as `M(~k, c, M(a, b, ~k))`, where `k = M(a, b, c)`.
- R7: `co_out` is the carry leaving the top slice. `8000_0000 + 8000_0000` gives sum 0 and `co_out`=1.
- R8: The block builds and adds correctly at WIDTH 16, 32 and 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | WIDTH | first addend |
| op_b | input | WIDTH | second addend |
| ci_in | input | 1 | carry into bit 0 |
| sum_out | output | WIDTH | sum bits |
| co_out | output | 1 | carry out of the top slice |

## Verification
The hardest case to reach from the ports is a carry that has to cross every slice through the outer vote alone. That needs each slice's inner votes to disagree, which happens only when both bits of every slice propagate without generating. The alternating operand pair with the carry-in set, and the all-ones-plus-carry vectors, build exactly that condition at every width. Each slice also checks its skipped carry against its internal bit-by-bit carry.

// File: rtl/mjadd_pkg.sv
package mjadd_pkg;

    localparam int unsigned MJ_DEF_WIDTH  = 32;
    localparam int unsigned MJ_SLICE_BITS = 2;

    // OR/AND pair of one bit position, both formed by votes
    typedef struct packed {
        logic prop;
        logic gen;
    } mj_pg_t;

    // three-input vote: the only logic primitive of the datapath
    function automatic logic mj_vote(input logic x, input logic y, input logic z);
        return (x & y) | (x & z) | (y & z);
    endfunction

endpackage

// File: rtl/mjadd_maj3.sv
module mjadd_maj3 (
    input  logic x,
    input  logic y,
    input  logic z,
    output logic v
);
    import mjadd_pkg::*;

    assign v = mj_vote(x, y, z);

endmodule

// File: rtl/mjadd_pg.sv
module mjadd_pg (
    input  logic            a,
    input  logic            b,
    output mjadd_pkg::mj_pg_t pg
);
    import mjadd_pkg::*;

    logic p_v, g_v;

    // OR: one vote input pinned high; AND: pinned low
    mjadd_maj3 u_or  (.x(a), .y(b), .z(1'b1), .v(p_v));
    mjadd_maj3 u_and (.x(a), .y(b), .z(1'b0), .v(g_v));

    assign pg = '{prop: p_v, gen: g_v};

    always_comb begin
        if (!$isunknown({a, b})) begin
            assert_pg_terms_R5: assert (pg.prop == (a || b) && pg.gen == (a && b))
                else $error("pg terms wrong for a=%b b=%b", a, b);
        end
    end

endmodule

// File: rtl/mjadd_bitcell.sv
module mjadd_bitcell (
    input  logic a,
    input  logic b,
    input  logic c,
    output logic s,
    output logic k
);
    logic k_n, mid;

    mjadd_maj3 u_carry (.x(a),   .y(b), .z(c),   .v(k));
    assign k_n = ~k;
    mjadd_maj3 u_mid   (.x(a),   .y(b), .z(k_n), .v(mid));
    mjadd_maj3 u_sum   (.x(k_n), .y(c), .z(mid), .v(s));

    always_comb begin
        if (!$isunknown({a, b, c})) begin
            assert_bit_sum_R6: assert ({k, s} == 2'(a) + 2'(b) + 2'(c))
                else $error("bit cell a=%b b=%b c=%b gave k=%b s=%b", a, b, c, k, s);
        end
    end

endmodule

// File: rtl/mjadd_slice.sv
module mjadd_slice
    import mjadd_pkg::*;
#(
    parameter int unsigned SB = MJ_SLICE_BITS
) (
    input  logic [SB-1:0] a,
    input  logic [SB-1:0] b,
    input  logic          cin,
    output logic [SB-1:0] sum,
    output logic          cout
);
    mj_pg_t lo_pg;
    logic   hi_gen_path, hi_prop_path;
    logic   c_mid, c_ripple;

    // stage 1: OR/AND of the lower bit
    mjadd_pg u_pg (.a(a[0]), .b(b[0]), .pg(lo_pg));

    // stage 2: the two inner votes do not depend on cin
    mjadd_maj3 u_hi_g (.x(a[1]), .y(b[1]), .z(lo_pg.gen),  .v(hi_gen_path));
    mjadd_maj3 u_hi_p (.x(a[1]), .y(b[1]), .z(lo_pg.prop), .v(hi_prop_path));
    // cin reaches the carry two positions up through this vote alone
    mjadd_maj3 u_skip (.x(hi_gen_path), .y(hi_prop_path), .z(cin), .v(cout));

    // stage 3: sum bits; the lower cell's local carry feeds the upper cell
    mjadd_bitcell u_b0 (.a(a[0]), .b(b[0]), .c(cin),   .s(sum[0]), .k(c_mid));
    mjadd_bitcell u_b1 (.a(a[1]), .b(b[1]), .c(c_mid), .s(sum[1]), .k(c_ripple));

    always_comb begin
        if (!$isunknown({a, b, cin})) begin
            assert_skip_carry_R4: assert (cout ==
                ((a[1] & b[1]) | ((a[1] | b[1]) & ((a[0] & b[0]) | ((a[0] | b[0]) & cin)))))
                else $error("slice carry %b wrong for a=%b b=%b cin=%b", cout, a, b, cin);
            assert_skip_vs_ripple_R4: assert (cout == c_ripple)
                else $error("skip carry %b differs from rippled carry %b", cout, c_ripple);
        end
    end

endmodule

// File: rtl/mjadd_top.sv
module mjadd_top
    import mjadd_pkg::*;
#(
    parameter int unsigned WIDTH = MJ_DEF_WIDTH
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             ci_in,
    output logic [WIDTH-1:0] sum_out,
    output logic             co_out
);
    localparam int unsigned NSLICE = WIDTH / MJ_SLICE_BITS;

    logic [NSLICE:0] chain;

    assign chain[0] = ci_in;

    for (genvar k = 0; k < NSLICE; k++) begin : g_slice
        mjadd_slice #(.SB(MJ_SLICE_BITS)) u_slice (
            .a   (op_a[k*MJ_SLICE_BITS +: MJ_SLICE_BITS]),
            .b   (op_b[k*MJ_SLICE_BITS +: MJ_SLICE_BITS]),
            .cin (chain[k]),
            .sum (sum_out[k*MJ_SLICE_BITS +: MJ_SLICE_BITS]),
            .cout(chain[k+1])
        );
    end

    assign co_out = chain[NSLICE];

    always_comb begin
        if (!$isunknown({op_a, op_b, ci_in})) begin
            assert_total_sum_R1: assert ({co_out, sum_out} ==
                ({1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, ci_in}))
                else $error("adder result %h wrong", {co_out, sum_out});
        end
    end

endmodule

// File: tb/sim_mjadd_top.sv
module sim_mjadd_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;  // 50 MHz

    logic [63:0] da, db;
    logic        dc;
    logic [15:0] s16;  logic c16;
    logic [31:0] s32;  logic c32;
    logic [63:0] s64;  logic c64;

    mjadd_top #(.WIDTH(32)) u0   (.op_a(da[31:0]), .op_b(db[31:0]), .ci_in(dc), .sum_out(s32), .co_out(c32));
    mjadd_top #(.WIDTH(16)) u16w (.op_a(da[15:0]), .op_b(db[15:0]), .ci_in(dc), .sum_out(s16), .co_out(c16));
    mjadd_top #(.WIDTH(64)) u64w (.op_a(da),       .op_b(db),       .ci_in(dc), .sum_out(s64), .co_out(c64));

    int checks = 0;
    int errors = 0;

    typedef struct packed {
        logic [31:0] a;
        logic [31:0] b;
        logic        cin;
        logic [32:0] res;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t TBL [NV] = '{
        '{32'h0000_0000, 32'h0000_0000, 1'b0, 33'h0_0000_0000},  // R1 zero
        '{32'hFFFF_FFFF, 32'h0000_0000, 1'b1, 33'h1_0000_0000},  // R2 carry-in into all ones
        '{32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 33'h1_0000_0000},  // R3 full propagation
        '{32'h5555_5555, 32'hAAAA_AAAA, 1'b0, 33'h0_FFFF_FFFF},  // R3 propagate, no carry
        '{32'h5555_5555, 32'hAAAA_AAAA, 1'b1, 33'h1_0000_0000},  // R4 carry through outer votes only
        '{32'h5555_5555, 32'h5555_5555, 1'b0, 33'h0_AAAA_AAAA},  // R4 generate in lower bits
        '{32'hAAAA_AAAA, 32'hAAAA_AAAA, 1'b0, 33'h1_5555_5554},  // R4 generate in upper bits
        '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 33'h1_FFFF_FFFF},  // R6 every bit sums three ones
        '{32'h1234_5678, 32'h8765_4321, 1'b0, 33'h0_9999_9999},  // R6 no carries
        '{32'h8000_0000, 32'h8000_0000, 1'b0, 33'h1_0000_0000},  // R7 top slice carry
        '{32'h0000_0001, 32'h7FFF_FFFF, 1'b0, 33'h0_8000_0000},  // R3 stops before the top
        '{32'hFFFF_FFFE, 32'h0000_0001, 1'b1, 33'h1_0000_0000}   // R2 cin completes the chain
    };

    task automatic check(input string req, input logic [64:0] got, input logic [64:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic apply(input logic [63:0] a, input logic [63:0] b, input logic c);
        @(posedge clk);
        da = a; db = b; dc = c;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        da = '0; db = '0; dc = 1'b0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // initial state: zero operands give zero result
        check("R1 idle", {32'h0, c32, s32}, 65'h0);

        for (int i = 0; i < NV; i++) begin
            apply({32'h0, TBL[i].a}, {32'h0, TBL[i].b}, TBL[i].cin);
            check($sformatf("R1 table %0d", i), {32'h0, c32, s32}, {32'h0, TBL[i].res});
        end

        // R5: generate with no carry in, and propagate of a carry in
        apply(64'h1, 64'h1, 1'b0);
        check("R5 generate", {32'h0, c32, s32}, 65'h2);
        apply(64'h1, 64'h0, 1'b1);
        check("R5 propagate", {32'h0, c32, s32}, 65'h2);

        // R8: full-length carry at 16 and 64 bits
        apply(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b1);
        check("R8 w16 ones+cin", {48'h0, c16, s16}, {48'h0, 17'h1_0000});
        check("R8 w64 ones+cin", {c64, s64}, {1'b1, 64'h0});
        apply(64'h5555_5555_5555_5555, 64'hAAAA_AAAA_AAAA_AAAA, 1'b0);
        check("R8 w16 alt", {48'h0, c16, s16}, {48'h0, 17'h0_FFFF});
        check("R8 w64 alt", {c64, s64}, {1'b0, 64'hFFFF_FFFF_FFFF_FFFF});

        // R1 and R8: random vectors at every width
        void'($urandom(32'd2024));
        for (int i = 0; i < 300; i++) begin
            logic [63:0] ra, rb;
            logic        rc;
            ra = {$urandom(), $urandom()};
            rb = {$urandom(), $urandom()};
            rc = 1'($urandom());
            apply(ra, rb, rc);
            check("R8 w16 random", {48'h0, c16, s16},
                  {48'h0, {1'b0, ra[15:0]} + {1'b0, rb[15:0]} + {16'h0, rc}});
            check("R1 w32 random", {32'h0, c32, s32},
                  {32'h0, {1'b0, ra[31:0]} + {1'b0, rb[31:0]} + {32'h0, rc}});
            check("R8 w64 random", {c64, s64},
                  {1'b0, ra} + {1'b0, rb} + {64'h0, rc});
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule